// File: doc/BRIEF.md
# Configurable Register Cell

A parameterized storage element whose width and feature set are fixed at elaboration. Parameters switch on a clock edge, a clock enable, a synchronous reset, a whole-register asynchronous reset, an asynchronous load gate, and per-bit asynchronous set and clear inputs. Every control input has its own polarity parameter. The cell resolves all active controls by a fixed priority and drives the result on `q_o`.

The cell is meant to be instantiated wherever a netlist needs one storage primitive that covers plain flops, enabled flops, flops with any one kind of reset, flops with an asynchronous load, and level-sensitive latches. When the clock feature is off, the cell becomes a level-sensitive latch built from whichever asynchronous controls are enabled. One parameter decides whether an inactive enable also blocks the synchronous reset. Feature combinations outside the legal set are rejected when the design is elaborated.

Top module: `cfgreg_cell`

## Requirements
- R1: From time zero, before any control acts, `q_o` equals the parameter `INIT_VAL`.
- R2: With the clock feature on, an active edge (rising when `POL_CLK` is 1, falling when 0) loads `d_i` when the enable is active (or absent) and the synchronous reset is inactive (or absent). The result is visible after that edge.
- R3: A bit whose clear input is active reads 0, and a bit whose set input is active reads 1. This happens at once without a clock edge, and it overrides async reset, async load and the clock for that bit.
- R4: When a bit's clear and set are both active, the bit reads 0.
- R5: An active async reset forces the whole register to `ARST_VAL` at once. It overrides async load and any clock edge.
- R6: While the async load gate is active, `q_o` follows `ad_i`, and clock edges have no effect. In latch mode the register stays transparent to `ad_i` changes during the gate. In edge mode `ad_i` must stay steady while the gate is active.
- R7: With `CE_OVER_SRST` = 1, an edge with the enable inactive leaves `q_o` unchanged even when the synchronous reset is active. With the enable active, the reset loads `SRST_VAL`.
- R8: With `CE_OVER_SRST` = 0, an edge with the synchronous reset active loads `SRST_VAL` whatever the enable is doing.
- R9: When no control condition applies (no active async control and no load at an edge), `q_o` keeps its value, including after async controls are released.
- R10: Each control input has a polarity parameter: 1 makes it active-high and 0 makes it active-low. For the clock, 1 selects the rising edge and 0 the falling edge.
- R11: At most one of sync reset, async reset and per-bit set/clear may be enabled. With both clock and async load on, none of them may be enabled. Enable and sync reset require the clock. An illegal choice raises an elaboration error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, edge chosen by `POL_CLK` |
| ce_i | input | 1 | Clock enable |
| srst_i | input | 1 | Synchronous reset to `SRST_VAL` |
| arst_i | input | 1 | Asynchronous whole-register reset to `ARST_VAL` |
| aload_i | input | 1 | Asynchronous load gate |
| d_i | input | WIDTH | Data loaded at a clock edge |
| ad_i | input | WIDTH | Data copied in while the load gate is active |
| clr_i | input | WIDTH | Per-bit asynchronous clear |
| set_i | input | WIDTH | Per-bit asynchronous set |
| q_o | output | WIDTH | Stored value |

## Verification
Clocked results (R2, R7, R8) are due at the first active edge after the inputs change. The bench drives those inputs 1 ns after a rising edge and samples 1 ns after the next rising edge. For the falling-edge instance it samples 1 ns after the falling edge. Asynchronous results (R3 to R6) need no edge. The bench changes one control away from any edge and samples 1 ns later, before the next edge can interfere. Hold checks (R9) are sampled after an edge or a release that must not change the value. Seven instances with different feature sets and polarities run side by side, and each is checked only in the scenarios built for its features.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    typedef enum logic [2:0] {
        ST_EDGE_PLAIN,
        ST_EDGE_ARST,
        ST_EDGE_SR,
        ST_EDGE_ALOAD,
        ST_LEVEL
    } store_kind_e;

    function automatic bit cfg_legal(bit has_clk, bit has_ce, bit has_srst,
                                     bit has_arst, bit has_aload, bit has_sr);
        int n_rst;
        n_rst = int'(has_srst) + int'(has_arst) + int'(has_sr);
        if (n_rst > 1) return 1'b0;
        if (has_clk && has_aload && n_rst != 0) return 1'b0;
        if (!has_clk && (has_ce || has_srst)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic store_kind_e pick_kind(bit has_clk, bit has_arst,
                                              bit has_aload, bit has_sr);
        if (has_clk && has_aload) return ST_EDGE_ALOAD;
        if (has_clk && has_sr)    return ST_EDGE_SR;
        if (has_clk && has_arst)  return ST_EDGE_ARST;
        if (has_clk)              return ST_EDGE_PLAIN;
        return ST_LEVEL;
    endfunction

    function automatic logic to_active(bit pol, logic lvl);
        return pol ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/cfgreg_ctl.sv
module cfgreg_ctl #(
    parameter int WIDTH     = 8,
    parameter bit HAS_CLK   = 1'b1,
    parameter bit HAS_CE    = 1'b0,
    parameter bit HAS_SRST  = 1'b0,
    parameter bit HAS_ARST  = 1'b0,
    parameter bit HAS_ALOAD = 1'b0,
    parameter bit HAS_SR    = 1'b0,
    parameter bit POL_CLK   = 1'b1,
    parameter bit POL_CE    = 1'b1,
    parameter bit POL_SRST  = 1'b1,
    parameter bit POL_ARST  = 1'b1,
    parameter bit POL_ALOAD = 1'b1,
    parameter bit POL_CLR   = 1'b1,
    parameter bit POL_SET   = 1'b1
) (
    input  logic             clk_i,
    input  logic             ce_i,
    input  logic             srst_i,
    input  logic             arst_i,
    input  logic             aload_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic [WIDTH-1:0] set_i,
    output logic             ck_o,
    output logic             ce_o,
    output logic             srst_o,
    output logic             arst_o,
    output logic             aload_o,
    output logic [WIDTH-1:0] clr_o,
    output logic [WIDTH-1:0] set_o
);
    import cfgreg_pkg::*;

    localparam logic [WIDTH-1:0] CLR_FLIP = POL_CLR ? '0 : '1;
    localparam logic [WIDTH-1:0] SET_FLIP = POL_SET ? '0 : '1;

    // Every output is active-high; a disabled feature reads as idle.
    assign ck_o    = HAS_CLK   ? to_active(POL_CLK, clk_i)     : 1'b0;
    assign ce_o    = HAS_CE    ? to_active(POL_CE, ce_i)       : 1'b1;
    assign srst_o  = HAS_SRST  ? to_active(POL_SRST, srst_i)   : 1'b0;
    assign arst_o  = HAS_ARST  ? to_active(POL_ARST, arst_i)   : 1'b0;
    assign aload_o = HAS_ALOAD ? to_active(POL_ALOAD, aload_i) : 1'b0;
    assign clr_o   = HAS_SR    ? (clr_i ^ CLR_FLIP)            : '0;
    assign set_o   = HAS_SR    ? (set_i ^ SET_FLIP)            : '0;

endmodule

// File: rtl/cfgreg_next.sv
module cfgreg_next #(
    parameter int               WIDTH        = 8,
    parameter bit               CE_OVER_SRST = 1'b0,
    parameter logic [WIDTH-1:0] SRST_VAL     = '0
) (
    input  logic             ce_i,
    input  logic             srst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic             ld_o,
    output logic [WIDTH-1:0] val_o
);
    typedef struct packed {
        logic             ld;
        logic [WIDTH-1:0] val;
    } nxt_t;

    nxt_t nxt_d;

    always_comb begin
        nxt_d.ld  = 1'b0;
        nxt_d.val = d_i;
        if (CE_OVER_SRST) begin
            // enable gates both the reset and the data load
            if (ce_i) begin
                nxt_d.ld  = 1'b1;
                nxt_d.val = srst_i ? SRST_VAL : d_i;
            end
        end else begin
            // reset acts on every edge; enable gates only the data load
            if (srst_i) begin
                nxt_d.ld  = 1'b1;
                nxt_d.val = SRST_VAL;
            end else if (ce_i) begin
                nxt_d.ld  = 1'b1;
            end
        end
    end

    assign ld_o  = nxt_d.ld;
    assign val_o = nxt_d.val;

endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store #(
    parameter int                       WIDTH    = 8,
    parameter cfgreg_pkg::store_kind_e  KIND     = cfgreg_pkg::ST_EDGE_PLAIN,
    parameter logic [WIDTH-1:0]         INIT_VAL = '0,
    parameter logic [WIDTH-1:0]         ARST_VAL = '0
) (
    input  logic             ck_i,
    input  logic             ld_i,
    input  logic [WIDTH-1:0] val_i,
    input  logic             arst_i,
    input  logic             aload_i,
    input  logic [WIDTH-1:0] ad_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic [WIDTH-1:0] set_i,
    output logic [WIDTH-1:0] q_o
);
    import cfgreg_pkg::*;

    logic unused_sink;
    assign unused_sink = ^{ck_i, ld_i, val_i, arst_i, aload_i, ad_i, clr_i, set_i};

    generate
        if (KIND == ST_EDGE_PLAIN) begin : g_plain
            logic [WIDTH-1:0] reg_q = INIT_VAL;
            always_ff @(posedge ck_i) begin
                if (ld_i) reg_q <= val_i;
            end
            assign q_o = reg_q;
        end else if (KIND == ST_EDGE_ARST) begin : g_arst
            logic [WIDTH-1:0] reg_q = INIT_VAL;
            always_ff @(posedge ck_i or posedge arst_i) begin
                if (arst_i)    reg_q <= ARST_VAL;
                else if (ld_i) reg_q <= val_i;
            end
            assign q_o = reg_q;
            // R5
            arst_force_chk: assert property (@(posedge ck_i) arst_i |-> q_o == ARST_VAL)
                else $error("async reset did not hold the reset constant");
        end else if (KIND == ST_EDGE_ALOAD) begin : g_aload
            logic [WIDTH-1:0] reg_q = INIT_VAL;
            always_ff @(posedge ck_i or posedge aload_i) begin
                if (aload_i)   reg_q <= ad_i;
                else if (ld_i) reg_q <= val_i;
            end
            assign q_o = aload_i ? ad_i : reg_q;
        end else if (KIND == ST_EDGE_SR) begin : g_sr
            for (genvar b = 0; b < WIDTH; b++) begin : g_bit
                logic bit_q = INIT_VAL[b];
                always_ff @(posedge ck_i or posedge clr_i[b] or posedge set_i[b]) begin
                    if (clr_i[b])      bit_q <= 1'b0;
                    else if (set_i[b]) bit_q <= 1'b1;
                    else if (ld_i)     bit_q <= val_i[b];
                end
                assign q_o[b] = bit_q;
                // R4
                clr_wins_chk: assert property (@(posedge ck_i) clr_i[b] |-> !q_o[b])
                    else $error("bit with clear active did not read zero");
            end
        end else begin : g_level
            for (genvar b = 0; b < WIDTH; b++) begin : g_bit
                logic bit_q = INIT_VAL[b];
                always_latch begin
                    if (clr_i[b])      bit_q = 1'b0;
                    else if (set_i[b]) bit_q = 1'b1;
                    else if (arst_i)   bit_q = ARST_VAL[b];
                    else if (aload_i)  bit_q = ad_i[b];
                end
                assign q_o[b] = bit_q;
            end
        end
    endgenerate

endmodule

// File: rtl/cfgreg_cell.sv
module cfgreg_cell #(
    parameter int               WIDTH        = 8,
    parameter bit               HAS_CLK      = 1'b1,
    parameter bit               HAS_CE       = 1'b1,
    parameter bit               HAS_SRST     = 1'b1,
    parameter bit               HAS_ARST     = 1'b0,
    parameter bit               HAS_ALOAD    = 1'b0,
    parameter bit               HAS_SR       = 1'b0,
    parameter bit               CE_OVER_SRST = 1'b0,
    parameter bit               POL_CLK      = 1'b1,
    parameter bit               POL_CE       = 1'b1,
    parameter bit               POL_SRST     = 1'b1,
    parameter bit               POL_ARST     = 1'b1,
    parameter bit               POL_ALOAD    = 1'b1,
    parameter bit               POL_CLR      = 1'b1,
    parameter bit               POL_SET      = 1'b1,
    parameter logic [WIDTH-1:0] INIT_VAL     = '0,
    parameter logic [WIDTH-1:0] ARST_VAL     = '0,
    parameter logic [WIDTH-1:0] SRST_VAL     = '0
) (
    input  logic             clk_i,
    input  logic             ce_i,
    input  logic             srst_i,
    input  logic             arst_i,
    input  logic             aload_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic [WIDTH-1:0] ad_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic [WIDTH-1:0] set_i,
    output logic [WIDTH-1:0] q_o
);
    import cfgreg_pkg::*;

    localparam bit          LEGAL = cfg_legal(HAS_CLK, HAS_CE, HAS_SRST,
                                              HAS_ARST, HAS_ALOAD, HAS_SR);
    localparam store_kind_e KIND  = pick_kind(HAS_CLK, HAS_ARST, HAS_ALOAD, HAS_SR);

    // R11
    initial begin
        legal_cfg_chk: assert (LEGAL)
            else $error("illegal feature combination for cfgreg_cell");
    end

    logic             ck, ce_a, srst_a, arst_a, ald_a;
    logic [WIDTH-1:0] clr_a, set_a;
    logic             ld;
    logic [WIDTH-1:0] nval;
    logic             async_any;

    cfgreg_ctl #(
        .WIDTH(WIDTH), .HAS_CLK(HAS_CLK), .HAS_CE(HAS_CE), .HAS_SRST(HAS_SRST),
        .HAS_ARST(HAS_ARST), .HAS_ALOAD(HAS_ALOAD), .HAS_SR(HAS_SR),
        .POL_CLK(POL_CLK), .POL_CE(POL_CE), .POL_SRST(POL_SRST),
        .POL_ARST(POL_ARST), .POL_ALOAD(POL_ALOAD), .POL_CLR(POL_CLR), .POL_SET(POL_SET)
    ) u_ctl (
        .clk_i(clk_i), .ce_i(ce_i), .srst_i(srst_i), .arst_i(arst_i),
        .aload_i(aload_i), .clr_i(clr_i), .set_i(set_i),
        .ck_o(ck), .ce_o(ce_a), .srst_o(srst_a), .arst_o(arst_a),
        .aload_o(ald_a), .clr_o(clr_a), .set_o(set_a)
    );

    cfgreg_next #(
        .WIDTH(WIDTH), .CE_OVER_SRST(CE_OVER_SRST), .SRST_VAL(SRST_VAL)
    ) u_next (
        .ce_i(ce_a), .srst_i(srst_a), .d_i(d_i), .ld_o(ld), .val_o(nval)
    );

    cfgreg_store #(
        .WIDTH(WIDTH), .KIND(KIND), .INIT_VAL(INIT_VAL), .ARST_VAL(ARST_VAL)
    ) u_store (
        .ck_i(ck), .ld_i(ld), .val_i(nval), .arst_i(arst_a), .aload_i(ald_a),
        .ad_i(ad_i), .clr_i(clr_a), .set_i(set_a), .q_o(q_o)
    );

    assign async_any = arst_a | ald_a | (|clr_a) | (|set_a);

    generate
        if (HAS_CLK && HAS_CE && HAS_SRST && CE_OVER_SRST) begin : g_chk_ce_over
            // R7
            ce_gates_srst_chk: assert property (@(posedge ck) disable iff (async_any)
                !ce_a |-> !ld)
                else $error("inactive enable did not block the edge");
        end
        if (HAS_CLK && HAS_SRST && !CE_OVER_SRST) begin : g_chk_srst
            // R8
            srst_wins_chk: assert property (@(posedge ck) disable iff (async_any)
                srst_a |-> (ld && nval == SRST_VAL))
                else $error("sync reset did not load its constant");
        end
    endgenerate

endmodule

// File: tb/sim_cfgreg_cell.sv
module sim_cfgreg_cell;

    logic       clk_i = 1'b0;
    logic       ce_i = 1'b0, srst_i = 1'b0, arst_i = 1'b0, aload_i = 1'b0;
    logic [7:0] d_i = 8'h00, ad_i = 8'h00, clr_i = 8'h00, set_i = 8'h00;
    logic       ce_n, arst_n;
    logic [7:0] q0, q1, q2, q3, q4, q5, q6;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    assign ce_n   = ~ce_i;
    assign arst_n = ~arst_i;

    always #5 clk_i = ~clk_i;

    // enable-over-reset, active-low enable
    cfgreg_cell #(.HAS_CE(1), .HAS_SRST(1), .CE_OVER_SRST(1), .POL_CE(0),
                  .INIT_VAL(8'hA5), .SRST_VAL(8'h3C))
        u0 (.*, .ce_i(ce_n), .q_o(q0));
    // reset-over-enable
    cfgreg_cell #(.HAS_CE(1), .HAS_SRST(1), .CE_OVER_SRST(0),
                  .INIT_VAL(8'h5A), .SRST_VAL(8'hC3))
        u1 (.*, .q_o(q1));
    // edge + enable + active-low async reset
    cfgreg_cell #(.HAS_CE(1), .HAS_SRST(0), .HAS_ARST(1), .POL_ARST(0),
                  .INIT_VAL(8'h00), .ARST_VAL(8'h81))
        u2 (.*, .arst_i(arst_n), .q_o(q2));
    // falling edge + per-bit set/clear
    cfgreg_cell #(.HAS_CE(0), .HAS_SRST(0), .HAS_SR(1), .POL_CLK(0),
                  .INIT_VAL(8'hF0))
        u3 (.*, .q_o(q3));
    // edge + enable + async load
    cfgreg_cell #(.HAS_CE(1), .HAS_SRST(0), .HAS_ALOAD(1), .INIT_VAL(8'h11))
        u4 (.*, .q_o(q4));
    // latch with set/clear
    cfgreg_cell #(.HAS_CLK(0), .HAS_CE(0), .HAS_SRST(0), .HAS_ALOAD(1), .HAS_SR(1),
                  .INIT_VAL(8'h22))
        u5 (.*, .q_o(q5));
    // latch with active-low async reset
    cfgreg_cell #(.HAS_CLK(0), .HAS_CE(0), .HAS_SRST(0), .HAS_ALOAD(1), .HAS_ARST(1),
                  .POL_ARST(0), .INIT_VAL(8'h33), .ARST_VAL(8'h7E))
        u6 (.*, .arst_i(arst_n), .q_o(q6));

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_i);
        #1;
    endtask

    task automatic ntick();
        @(negedge clk_i);
        #1;
    endtask

    task automatic t_init();
        #1;
        chk("R1", "u0 init", q0, 8'hA5);
        chk("R1", "u1 init", q1, 8'h5A);
        chk("R1", "u2 init", q2, 8'h00);
        chk("R1", "u3 init", q3, 8'hF0);
        chk("R1", "u4 init", q4, 8'h11);
        chk("R1", "u5 init", q5, 8'h22);
        chk("R1", "u6 init", q6, 8'h33);
    endtask

    task automatic t_sync_prio();
        tick();
        ce_i = 1'b1; srst_i = 1'b0; d_i = 8'h11;
        tick();
        chk("R2", "u0 load", q0, 8'h11);
        chk("R2", "u1 load", q1, 8'h11);
        ce_i = 1'b0; srst_i = 1'b1;
        tick();
        chk("R7", "u0 enable blocks reset", q0, 8'h11);
        chk("R8", "u1 reset without enable", q1, 8'hC3);
        ce_i = 1'b1;
        tick();
        chk("R7", "u0 reset with enable", q0, 8'h3C);
        chk("R8", "u1 reset with enable", q1, 8'hC3);
        ce_i = 1'b0; srst_i = 1'b0; d_i = 8'h99;
        tick();
        chk("R9", "u0 hold", q0, 8'h3C);
        chk("R9", "u1 hold", q1, 8'hC3);
    endtask

    task automatic t_arst();
        ce_i = 1'b1; d_i = 8'h44;
        tick();
        chk("R2", "u2 load", q2, 8'h44);
        arst_i = 1'b1; aload_i = 1'b1; ad_i = 8'h55;
        #1;
        chk("R5", "u2 async reset", q2, 8'h81);
        chk("R10", "u6 active-low reset over load", q6, 8'h7E);
        tick();
        chk("R5", "u2 reset over edge", q2, 8'h81);
        arst_i = 1'b0;
        #1;
        chk("R6", "u6 transparent", q6, 8'h55);
        ad_i = 8'h66;
        #1;
        chk("R6", "u6 follows", q6, 8'h66);
        aload_i = 1'b0;
        #1;
        ad_i = 8'h77;
        #1;
        chk("R9", "u6 hold after gate", q6, 8'h66);
        tick();
        chk("R9", "u2 edge after release", q2, 8'h44);
        ce_i = 1'b0;
    endtask

    task automatic t_sr_edge();
        d_i = 8'hAA;
        ntick();
        chk("R10", "u3 falling edge load", q3, 8'hAA);
        clr_i = 8'h0F; set_i = 8'h30;
        #1;
        chk("R3", "u3 set/clear", q3, 8'hB0);
        d_i = 8'h00;
        ntick();
        chk("R3", "u3 set/clear over edge", q3, 8'h30);
        set_i = 8'h3C;
        #1;
        chk("R4", "u3 clear wins", q3, 8'h30);
        clr_i = 8'h00; set_i = 8'h00;
        #1;
        chk("R9", "u3 hold on release", q3, 8'h30);
        d_i = 8'h5A;
        ntick();
        chk("R2", "u3 load after release", q3, 8'h5A);
    endtask

    task automatic t_aload_edge();
        tick();
        ce_i = 1'b1; d_i = 8'h12;
        tick();
        chk("R2", "u4 load", q4, 8'h12);
        aload_i = 1'b1; ad_i = 8'hE7;
        #1;
        chk("R6", "u4 async load", q4, 8'hE7);
        tick();
        chk("R6", "u4 load gate over edge", q4, 8'hE7);
        aload_i = 1'b0;
        #1;
        chk("R9", "u4 hold after gate", q4, 8'hE7);
        tick();
        chk("R2", "u4 edge after gate", q4, 8'h12);
        ce_i = 1'b0;
    endtask

    task automatic t_latch_sr();
        clr_i = 8'h00; set_i = 8'h00;
        aload_i = 1'b1; ad_i = 8'h0F;
        #1;
        chk("R6", "u5 transparent", q5, 8'h0F);
        clr_i = 8'h03;
        #1;
        chk("R3", "u5 clear over load", q5, 8'h0C);
        set_i = 8'hF0;
        #1;
        chk("R3", "u5 set over load", q5, 8'hFC);
        clr_i = 8'h00;
        #1;
        chk("R3", "u5 clear release", q5, 8'hFF);
        aload_i = 1'b0;
        #1;
        set_i = 8'h00;
        #1;
        ad_i = 8'h00;
        #1;
        chk("R9", "u5 hold", q5, 8'hFF);
        clr_i = 8'hFF; set_i = 8'h01;
        #1;
        chk("R4", "u5 clear wins", q5, 8'h00);
        clr_i = 8'h00; set_i = 8'h00;
        #1;
        chk("R9", "u5 hold after release", q5, 8'h00);
    endtask

    initial begin
        t_init();
        t_sync_prio();
        t_arst();
        t_sr_edge();
        t_aload_edge();
        t_latch_sr();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule